// File: doc/BRIEF.md
# Speculative Register Checkpoint and Gated Store Unit

This block holds a small architectural register file in two copies. One is a working copy that ordinary writes change. The other is a checkpoint copy that changes only when a commit is signalled. Beside the registers sits a gated store queue. Stores taken from the pipeline wait in this queue and do not reach memory until the region they belong to is committed.

A one-cycle commit pulse does two things: it captures every working register into its checkpoint, and it marks every queued store as releasable. Released stores then leave through a valid/ready memory write port, oldest first, at most one per cycle. A one-cycle rollback pulse, raised when an exception makes the speculative work invalid, does the opposite. Every working register is reloaded from its checkpoint, and every store that has not yet been committed is thrown away. Stores that were already committed still drain to memory.

The register file has two read ports and one write port, and both read ports return the working copy.

Top module: `spec_ckpt_unit`

## Requirements
- R1: Both read ports return the working copy of the indexed register without delay; a write becomes visible on the read ports after the clock edge that takes it.
- R2: A register write outside a commit cycle changes the working copy only; a later rollback brings back the value held before the write.
- R3: A commit copies all working registers into their checkpoints in one cycle; a register write in the commit cycle is part of what is captured.
- R4: A rollback reloads all working registers from their checkpoints in one cycle; a register write in the rollback cycle is discarded.
- R5: A queued store never appears on the memory port (mem_valid stays 0) until a commit; a store accepted in the commit cycle itself belongs to the committed group.
- R6: After a commit, the committed stores leave in the order they were accepted, one per cycle while mem_ready is 1; while mem_ready is 0, mem_valid stays 1 with mem_addr and mem_data unchanged.
- R7: A rollback drops every uncommitted store, including one accepted in the rollback cycle, and none of them ever reaches memory; stores committed earlier still drain.
- R8: Stores accepted while earlier committed stores are still draining are held until the next commit.
- R9: When commit and rollback are raised in the same cycle, the rollback takes effect and the commit has no effect.
- R10: st_ready is 0 exactly when the queue holds SB_DEPTH entries, counting both committed and uncommitted ones; a store offered while st_ready is 0 is not taken.
- R11: After reset, both copies of every register are zero, the queue is empty, mem_valid is 0 and st_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | $clog2(NREG) | Read port A register index |
| rd_a_data | output | DW | Read port A working value |
| rd_b_idx | input | $clog2(NREG) | Read port B register index |
| rd_b_data | output | DW | Read port B working value |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | $clog2(NREG) | Register write index |
| wr_data | input | DW | Register write value |
| st_valid | input | 1 | Store offered to the queue |
| st_ready | output | 1 | Queue can accept a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| commit_i | input | 1 | Commit pulse |
| rollback_i | input | 1 | Rollback pulse |
| mem_valid | output | 1 | Committed store presented to memory |
| mem_ready | input | 1 | Memory accepts the presented store |
| mem_addr | output | AW | Address of the presented store |
| mem_data | output | DW | Data of the presented store |

## Verification
Commit and rollback can be raised in the same cycle. The bench sets this up by overwriting a register that was already checkpointed and queuing a fresh store. It then raises both pulses together. The register must read back its checkpoint value, and a later plain commit must send nothing to memory.

A register write or a store enqueue can also coincide with either pulse. The bench drives each of these pairings in one cycle and judges the result from the read ports and from the memory transactions it logs.

// File: rtl/spec_ckpt_pkg.sv
package spec_ckpt_pkg;

   // Resolved control action for one cycle
   typedef enum logic [1:0] {
      CK_NONE     = 2'd0,
      CK_COMMIT   = 2'd1,
      CK_ROLLBACK = 2'd2
   } ck_op_e;

   // Rollback outranks commit when both are raised
   function automatic ck_op_e resolve_op(input logic cm, input logic rb);
      if (rb)      return CK_ROLLBACK;
      else if (cm) return CK_COMMIT;
      else         return CK_NONE;
   endfunction

endpackage

// File: rtl/spec_op_arb.sv
module spec_op_arb
   import spec_ckpt_pkg::*;
(
   input  logic   commit_i,
   input  logic   rollback_i,
   output ck_op_e op
);

   always_comb begin
      op = resolve_op(commit_i, rollback_i);
   end

endmodule

// File: rtl/spec_regfile.sv
module spec_regfile
   import spec_ckpt_pkg::*;
#(
   parameter int NREG = 16,
   parameter int DW   = 32,
   localparam int IW  = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  ck_op_e                    op,
   input  logic                      wr_en,
   input  logic [IW-1:0]             wr_idx,
   input  logic [DW-1:0]             wr_data,
   input  logic [IW-1:0]             rd_a_idx,
   input  logic [IW-1:0]             rd_b_idx,
   output logic [DW-1:0]             rd_a_data,
   output logic [DW-1:0]             rd_b_data,
   output logic [NREG-1:0][DW-1:0]   work_q,
   output logic [NREG-1:0][DW-1:0]   shad_q
);

   if (NREG < 2) begin : g_bad_nreg
      $error("spec_regfile: NREG must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("spec_regfile: DW must be positive");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic          hit;
      logic [DW-1:0] next_work;

      assign hit       = wr_en && (wr_idx == IW'(i));
      assign next_work = hit ? wr_data : work_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            work_q[i] <= '0;
            shad_q[i] <= '0;
         end else begin
            unique case (op)
               CK_ROLLBACK: work_q[i] <= shad_q[i];
               CK_COMMIT: begin
                  work_q[i] <= next_work;
                  shad_q[i] <= next_work;
               end
               default: work_q[i] <= next_work;
            endcase
         end
      end
   end

   if (NREG == (1 << IW)) begin : g_rd_full
      assign rd_a_data = work_q[rd_a_idx];
      assign rd_b_data = work_q[rd_b_idx];
   end else begin : g_rd_guard
      assign rd_a_data = (32'(rd_a_idx) < NREG) ? work_q[rd_a_idx] : '0;
      assign rd_b_data = (32'(rd_b_idx) < NREG) ? work_q[rd_b_idx] : '0;
   end

endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
   import spec_ckpt_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ck_op_e        op,
   input  logic          st_valid,
   output logic          st_ready,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   output logic          mem_valid,
   input  logic          mem_ready,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_data,
   output logic [PW:0]   occ
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spec_store_buf: DEPTH must be a power of two, at least 2");
   end

   localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

   logic [AW-1:0] addr_q [DEPTH];
   logic [DW-1:0] data_q [DEPTH];

   // head: oldest entry, cmt: end of committed group, tail: next free slot
   logic [PW:0] head_q, cmt_q, tail_q;
   logic [PW:0] tail_n;
   logic        push, pop;

   assign occ       = tail_q - head_q;
   assign st_ready  = (occ != FULL_CNT);
   assign push      = st_valid && st_ready;
   assign mem_valid = (head_q != cmt_q);
   assign pop       = mem_valid && mem_ready;
   assign tail_n    = tail_q + {{PW{1'b0}}, push};
   assign mem_addr  = addr_q[head_q[PW-1:0]];
   assign mem_data  = data_q[head_q[PW-1:0]];

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[tail_q[PW-1:0]] <= st_addr;
         data_q[tail_q[PW-1:0]] <= st_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         cmt_q  <= '0;
         tail_q <= '0;
      end else begin
         if (pop) head_q <= head_q + 1'b1;
         unique case (op)
            CK_COMMIT: begin
               cmt_q  <= tail_n;
               tail_q <= tail_n;
            end
            CK_ROLLBACK: tail_q <= cmt_q;
            default:     tail_q <= tail_n;
         endcase
      end
   end

endmodule

// File: rtl/spec_ckpt_unit.sv
module spec_ckpt_unit
   import spec_ckpt_pkg::*;
#(
   parameter int NREG     = 16,
   parameter int DW       = 32,
   parameter int AW       = 32,
   parameter int SB_DEPTH = 8,
   localparam int IW      = $clog2(NREG),
   localparam int PW      = $clog2(SB_DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_a_idx,
   output logic [DW-1:0] rd_a_data,
   input  logic [IW-1:0] rd_b_idx,
   output logic [DW-1:0] rd_b_data,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic          st_valid,
   output logic          st_ready,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   input  logic          commit_i,
   input  logic          rollback_i,
   output logic          mem_valid,
   input  logic          mem_ready,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_data
);

   ck_op_e                  op;
   logic [NREG-1:0][DW-1:0] work_q;
   logic [NREG-1:0][DW-1:0] shad_q;
   logic [PW:0]             sb_occ;

   spec_op_arb u_arb (
      .commit_i   (commit_i),
      .rollback_i (rollback_i),
      .op         (op)
   );

   spec_regfile #(.NREG(NREG), .DW(DW)) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_a_idx  (rd_a_idx),
      .rd_b_idx  (rd_b_idx),
      .rd_a_data (rd_a_data),
      .rd_b_data (rd_b_data),
      .work_q    (work_q),
      .shad_q    (shad_q)
   );

   spec_store_buf #(.DEPTH(SB_DEPTH), .AW(AW), .DW(DW)) u_sb (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .st_valid  (st_valid),
      .st_ready  (st_ready),
      .st_addr   (st_addr),
      .st_data   (st_data),
      .mem_valid (mem_valid),
      .mem_ready (mem_ready),
      .mem_addr  (mem_addr),
      .mem_data  (mem_data),
      .occ       (sb_occ)
   );

endmodule

// File: rtl/spec_ckpt_chk.sv
module spec_ckpt_chk #(
   parameter int NREG     = 16,
   parameter int DW       = 32,
   parameter int AW       = 32,
   parameter int SB_DEPTH = 8,
   localparam int PW      = $clog2(SB_DEPTH)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic                    commit_i,
   input logic                    rollback_i,
   input logic                    st_ready,
   input logic                    mem_valid,
   input logic                    mem_ready,
   input logic [AW-1:0]           mem_addr,
   input logic [DW-1:0]           mem_data,
   input logic [NREG-1:0][DW-1:0] work_q,
   input logic [NREG-1:0][DW-1:0] shad_q,
   input logic [PW:0]             sb_occ
);

   // R4
   rb_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rollback_i |=> (work_q == $past(shad_q)));

   // R2
   shad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_i && !rollback_i) |=> (shad_q == $past(shad_q)));

   // R3
   cm_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && !rollback_i && !wr_en) |=> (shad_q == $past(work_q)));

   // R9
   cm_rb_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && rollback_i) |=> (shad_q == $past(shad_q)));

   // R6
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

   // R10
   full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_ready |-> (sb_occ == (PW+1)'(SB_DEPTH)));

   // R10
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sb_occ <= (PW+1)'(SB_DEPTH));

endmodule

bind spec_ckpt_unit spec_ckpt_chk #(
   .NREG(NREG), .DW(DW), .AW(AW), .SB_DEPTH(SB_DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .commit_i   (commit_i),
   .rollback_i (rollback_i),
   .st_ready   (st_ready),
   .mem_valid  (mem_valid),
   .mem_ready  (mem_ready),
   .mem_addr   (mem_addr),
   .mem_data   (mem_data),
   .work_q     (work_q),
   .shad_q     (shad_q),
   .sb_occ     (sb_occ)
);

// File: tb/spec_ckpt_unit_tb.sv
`timescale 1ns/1ps
module spec_ckpt_unit_tb;

   localparam int CLK_P = 10;
   localparam int NREG  = 16;
   localparam int DW    = 32;
   localparam int AW    = 32;
   localparam int DEPTH = 8;
   localparam int IW    = $clog2(NREG);

   logic          clk = 0;
   logic          rst_n = 0;
   logic [IW-1:0] rd_a_idx = '0, rd_b_idx = '0;
   logic [DW-1:0] rd_a_data, rd_b_data;
   logic          wr_en = 0;
   logic [IW-1:0] wr_idx = '0;
   logic [DW-1:0] wr_data = '0;
   logic          st_valid = 0;
   logic          st_ready;
   logic [AW-1:0] st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic          commit_i = 0, rollback_i = 0;
   logic          mem_valid;
   logic          mem_ready = 1;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_data;

   int vectors = 0;
   int fails   = 0;

   logic [AW-1:0] log_addr [64];
   logic [DW-1:0] log_data [64];
   int            mem_n = 0;

   spec_ckpt_unit #(.NREG(NREG), .DW(DW), .AW(AW), .SB_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
      .commit_i(commit_i), .rollback_i(rollback_i),
      .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_data(mem_data)
   );

   always #(CLK_P/2) clk = ~clk;

   // Memory-side logger: samples one time unit before each rising edge
   always begin
      @(negedge clk);
      #(CLK_P/2 - 1);
      if (rst_n && mem_valid && mem_ready && mem_n < 64) begin
         log_addr[mem_n] = mem_addr;
         log_data[mem_n] = mem_data;
         mem_n++;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // One cycle of stimulus; returns one time unit after the edge
   task automatic drive(input logic we, input int wi, input logic [31:0] wd,
                        input logic sv, input logic [31:0] sa, input logic [31:0] sd,
                        input logic cm, input logic rb);
      @(negedge clk);
      wr_en = we; wr_idx = IW'(wi); wr_data = wd;
      st_valid = sv; st_addr = sa; st_data = sd;
      commit_i = cm; rollback_i = rb;
      @(posedge clk);
      #1;
      wr_en = 0; st_valid = 0; commit_i = 0; rollback_i = 0;
   endtask

   task automatic wr(input int i, input logic [31:0] d);
      drive(1, i, d, 0, 0, 0, 0, 0);
   endtask

   task automatic push(input logic [31:0] a, input logic [31:0] d);
      drive(0, 0, 0, 1, a, d, 0, 0);
   endtask

   task automatic commit();
      drive(0, 0, 0, 0, 0, 0, 1, 0);
   endtask

   task automatic rollback();
      drive(0, 0, 0, 0, 0, 0, 0, 1);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic rd_chk(input string req, input int i, input logic [31:0] exp);
      rd_a_idx = IW'(i);
      rd_b_idx = IW'(i);
      #1;
      chk(req, rd_a_data, exp);
      chk(req, rd_b_data, exp);
   endtask

   task automatic set_ready(input logic r);
      @(negedge clk);
      mem_ready = r;
   endtask

   task automatic t_reset();
      chk("R11 st_ready", 32'(st_ready), 1);
      chk("R11 mem_valid", 32'(mem_valid), 0);
      rd_chk("R11 working reg0", 0, 0);
      rd_chk("R11 working reg15", NREG-1, 0);
      rollback();
      rd_chk("R11 checkpoint reg9", 9, 0);
   endtask

   task automatic t_read_write();
      wr(3, 32'hA5A5_0003);
      rd_chk("R1 read after write", 3, 32'hA5A5_0003);
      wr(12, 32'h0000_BEEF);
      rd_chk("R1 second reg", 12, 32'h0000_BEEF);
      rd_chk("R1 first reg kept", 3, 32'hA5A5_0003);
   endtask

   task automatic t_ckpt_all();
      for (int i = 0; i < NREG; i++) wr(i, 32'h1000_0000 + 32'(i));
      commit();
      for (int i = 0; i < NREG; i++) wr(i, 32'h2000_0000 + 32'(i));
      rd_chk("R1 working after overwrite", 5, 32'h2000_0005);
      rollback();
      for (int i = 0; i < NREG; i++) rd_chk("R3 R4 all regs restored", i, 32'h1000_0000 + 32'(i));
      // write in commit cycle is captured
      drive(1, 4, 32'hC0DE_0004, 0, 0, 0, 1, 0);
      wr(4, 32'h0);
      rollback();
      rd_chk("R3 write in commit cycle captured", 4, 32'hC0DE_0004);
      // write in rollback cycle is dropped
      wr(6, 32'h6666_6666);
      drive(1, 6, 32'h7777_7777, 0, 0, 0, 0, 1);
      rd_chk("R4 write in rollback cycle dropped", 6, 32'h1000_0006);
      rd_chk("R2 untouched shadow", 6, 32'h1000_0006);
   endtask

   task automatic t_store_gate();
      int base;
      base = mem_n;
      set_ready(1);
      push(32'h100, 32'hD0);
      push(32'h104, 32'hD1);
      idle(3);
      chk("R5 nothing before commit", 32'(mem_n - base), 0);
      chk("R5 mem_valid low", 32'(mem_valid), 0);
      drive(0, 0, 0, 1, 32'h108, 32'hD2, 1, 0);
      idle(5);
      chk("R6 drained count", 32'(mem_n - base), 3);
      for (int k = 0; k < 3; k++) begin
         chk("R6 order addr", log_addr[base+k], 32'h100 + 32'(4*k));
         chk("R5 R6 order data", log_data[base+k], 32'hD0 + 32'(k));
      end
   endtask

   task automatic t_store_drop();
      int base;
      base = mem_n;
      push(32'h200, 32'hE0);
      drive(0, 0, 0, 1, 32'h204, 32'hE1, 0, 1);
      commit();
      idle(4);
      chk("R7 uncommitted dropped", 32'(mem_n - base), 0);
      set_ready(0);
      push(32'h300, 32'hF0);
      commit();
      push(32'h304, 32'hF1);
      rollback();
      set_ready(1);
      idle(4);
      chk("R7 committed survives rollback", 32'(mem_n - base), 1);
      chk("R7 survivor addr", log_addr[base], 32'h300);
      commit();
      idle(3);
      chk("R7 dropped store never sent", 32'(mem_n - base), 1);
   endtask

   task automatic t_backpressure();
      int base;
      base = mem_n;
      set_ready(0);
      push(32'h400, 32'h40);
      push(32'h404, 32'h41);
      commit();
      idle(2);
      chk("R6 held valid", 32'(mem_valid), 1);
      chk("R6 held addr", mem_addr, 32'h400);
      chk("R6 held data", mem_data, 32'h40);
      push(32'h408, 32'h42);
      set_ready(1);
      idle(4);
      chk("R8 only first group drained", 32'(mem_n - base), 2);
      chk("R8 next group gated", 32'(mem_valid), 0);
      commit();
      idle(3);
      chk("R8 next group after commit", 32'(mem_n - base), 3);
      chk("R8 addr", log_addr[base+2], 32'h408);
   endtask

   task automatic t_collide();
      int base;
      drive(1, 7, 32'h5050_0007, 0, 0, 0, 1, 0);
      wr(7, 32'h6060_0007);
      base = mem_n;
      push(32'h500, 32'h55);
      drive(0, 0, 0, 0, 0, 0, 1, 1);
      rd_chk("R9 rollback wins on reg", 7, 32'h5050_0007);
      idle(2);
      chk("R9 no store released", 32'(mem_n - base), 0);
      commit();
      idle(3);
      chk("R9 store dropped", 32'(mem_n - base), 0);
   endtask

   task automatic t_full();
      int base;
      base = mem_n;
      set_ready(0);
      for (int k = 0; k < DEPTH; k++) push(32'h600 + 32'(4*k), 32'h60 + 32'(k));
      chk("R10 ready low when full", 32'(st_ready), 0);
      push(32'h6FC, 32'hFF);
      commit();
      chk("R10 committed still occupy", 32'(st_ready), 0);
      @(negedge clk);
      mem_ready = 1;
      @(posedge clk);
      #1;
      mem_ready = 0;
      chk("R10 ready after one drain", 32'(st_ready), 1);
      set_ready(1);
      idle(DEPTH + 2);
      chk("R10 offered-while-full not taken", 32'(mem_n - base), DEPTH);
      chk("R6 last of full queue", log_addr[base+DEPTH-1], 32'h600 + 32'(4*(DEPTH-1)));
   endtask

   initial begin
      #(CLK_P * 200000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      t_reset();
      t_read_write();
      t_ckpt_all();
      t_store_gate();
      t_store_drop();
      t_backpressure();
      t_collide();
      t_full();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule